// File: doc/BRIEF.md
# Host-Side FIFO and Mailbox Register Port

This block is the host-facing register window of a board that talks to its host through two external FIFOs and two small mailboxes. The host sees a flat window addressed by a 3-bit offset, with no indirection. An 8-bit host bus reaches a data port, a staging byte for the upper half of 16-bit data words, a status/control location, a mailbox location and a write-only reset trigger. A data-port write produces a push strobe toward the outbound FIFO. A data-port read returns the head of the inbound FIFO and produces a pop strobe.

Besides the data path, the block holds a 6-bit outbound mailbox that the host writes and the board consumes. It also holds a 6-bit inbound mailbox that the board fills and the host drains. Each mailbox has a pending flag. The block turns the two FIFO occupancy counts into full, empty and half-full flags. It combines them with the mailbox flags into one status byte, and drives an interrupt from the conditions the host has enabled. A word-mode input selects whether a data access moves 16 bits or only the low byte.

Top module: `fifo_mbox_hostif`

## Requirements
- R1: Reading offset 2 returns the status byte. Bit 7 is outbound mailbox pending, bit 6 is outbound FIFO full (level equal to DEPTH), bit 5 is inbound FIFO empty (level 0), bit 4 is outbound half full, bit 3 is inbound half full, bit 2 is inbound mailbox full, bit 1 is inbound FIFO full and bit 0 is outbound FIFO empty. A FIFO counts as half full when twice its level is at least DEPTH.
- R2: A host write at offset 0 raises `out_push` in the same cycle unless the outbound level equals DEPTH. In word mode the pushed word is {byte last written at offset 1, write data}. In byte mode it is {8'h00, write data}. A write at offset 1 never pushes.
- R3: A host read at offset 0 returns `in_pop_data[7:0]` in the same cycle and raises `in_pop` unless the inbound level is 0. In word mode a pop captures `in_pop_data[15:8]`, which a later read at offset 1 returns. In byte mode a read at offset 1 returns 8'h00. A read at offset 1 never pops.
- R4: A host write at offset 3 stores write data bits [7:2] in the outbound mailbox, drives them on `out_mb_data` and sets status bit 7 from the next cycle. `brd_mb_take` clears status bit 7 and leaves `out_mb_data` unchanged. If both happen in the same cycle, the host write wins.
- R5: `brd_mb_put` stores `brd_mb_wdata` in the inbound mailbox and sets status bit 2 from the next cycle. A host read at offset 3 with the readback select clear returns {mailbox, 2'b00} and clears status bit 2. If both happen in the same cycle, the board put wins.
- R6: Bit 7 of the control byte written at offset 2 is the readback select. It is clear after reset. While it is set, a read at offset 3 returns {outbound mailbox, 2'b00} and leaves both mailbox flags unchanged.
- R7: `irq` is high when `irq_en` is high and at least one enabled condition holds. Control bit 6 enables status bit 2, bit 5 enables status bit 1, bit 3 enables status bit 5, bit 2 enables status bit 6 and bit 0 enables status bit 0. When `irq_en` is low, `irq` is low.
- R8: Control bits 4 and 1 are reserved and are not stored. Writing them enables no interrupt, not even for the status bits that share their positions (4 and 1).
- R9: A host write at offset 7 with any data drives `board_rst` high for exactly the next cycle. A host read at offset 7 returns 8'h00, pops nothing and changes no flag.
- R10: After reset both mailbox flags are clear, every control bit is clear, `irq` and `board_rst` are low, and status follows the occupancy inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_mode | input | 1 | 1: data accesses move 16 bits; 0: low byte only |
| host_addr | input | 3 | Register offset of the host access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid in the read cycle |
| out_push | output | 1 | Push strobe to the outbound FIFO |
| out_push_data | output | 16 | Word pushed to the outbound FIFO |
| out_level | input | LW | Outbound FIFO occupancy |
| in_pop | output | 1 | Pop strobe to the inbound FIFO |
| in_pop_data | input | 16 | Head word of the inbound FIFO |
| in_level | input | LW | Inbound FIFO occupancy |
| brd_mb_take | input | 1 | Board consumed the outbound mailbox |
| brd_mb_put | input | 1 | Board writes the inbound mailbox |
| brd_mb_wdata | input | 6 | Board data for the inbound mailbox |
| out_mb_data | output | 6 | Outbound mailbox contents for the board |
| board_rst | output | 1 | One-cycle board reset pulse |
| irq_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request to the host |

## Verification
Read data, `out_push`, `out_push_data` and `in_pop` belong to the cycle of the host strobe. The bench drives each access just after a falling edge and compares them 1 ns later in that same low phase. Mailbox flags, the control byte and the staging bytes change at the rising edge that ends the access, so status, mailbox reads and `irq` are checked only in a later access, after the strobe has been dropped. `board_rst` is due in the single cycle after the write at offset 7. It is sampled low during the write, high one cycle later and low again the cycle after that. Expected read values go into a scoreboard queue when the access is issued, and a monitor compares them at the sample point of each read cycle.

// File: rtl/fifo_mbox_hostif_pkg.sv
package fifo_mbox_hostif_pkg;

  // register offsets (host side)
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_HIGH = 3'd1;
  localparam logic [2:0] OFS_CTRL = 3'd2;
  localparam logic [2:0] OFS_MAIL = 3'd3;
  localparam logic [2:0] OFS_KICK = 3'd7;

  // status bit positions
  localparam int ST_OMB    = 7;
  localparam int ST_OFULL  = 6;
  localparam int ST_IEMPTY = 5;
  localparam int ST_OHALF  = 4;
  localparam int ST_IHALF  = 3;
  localparam int ST_IMB    = 2;
  localparam int ST_IFULL  = 1;
  localparam int ST_OEMPTY = 0;

  // control byte positions
  localparam int CT_RSEL   = 7;
  localparam int CT_IMB    = 6;
  localparam int CT_IFULL  = 5;
  localparam int CT_IEMPTY = 3;
  localparam int CT_OFULL  = 2;
  localparam int CT_OEMPTY = 0;

  localparam int NUM_EN = 5;

  // pick the enable bits out of a control byte, reserved bits dropped
  function automatic logic [NUM_EN-1:0] ctrl_enables(input logic [7:0] c);
    return {c[CT_IMB], c[CT_IFULL], c[CT_IEMPTY], c[CT_OFULL], c[CT_OEMPTY]};
  endfunction

  // status bits gated by the matching enable bits
  function automatic logic [NUM_EN-1:0] irq_hits(input logic [7:0] st,
                                                 input logic [NUM_EN-1:0] en);
    logic [NUM_EN-1:0] src;
    src = {st[ST_IMB], st[ST_IFULL], st[ST_IEMPTY], st[ST_OFULL], st[ST_OEMPTY]};
    return src & en;
  endfunction

  function automatic logic at_half(input int unsigned lvl, input int unsigned depth);
    return (2 * lvl) >= depth;
  endfunction

endpackage

// File: rtl/fifo_mbox_hostif_decode.sv
module fifo_mbox_hostif_decode
  import fifo_mbox_hostif_pkg::*;
(
  input  logic [2:0] addr,
  input  logic       wr,
  input  logic       rd,
  output logic       wr_data,
  output logic       wr_high,
  output logic       wr_ctrl,
  output logic       wr_mail,
  output logic       wr_kick,
  output logic       rd_data,
  output logic       rd_high,
  output logic       rd_ctrl,
  output logic       rd_mail
);
  always_comb begin
    wr_data = wr && (addr == OFS_DATA);
    wr_high = wr && (addr == OFS_HIGH);
    wr_ctrl = wr && (addr == OFS_CTRL);
    wr_mail = wr && (addr == OFS_MAIL);
    wr_kick = wr && (addr == OFS_KICK);
    rd_data = rd && (addr == OFS_DATA);
    rd_high = rd && (addr == OFS_HIGH);
    rd_ctrl = rd && (addr == OFS_CTRL);
    rd_mail = rd && (addr == OFS_MAIL);
  end
endmodule

// File: rtl/fifo_mbox_hostif_mailbox.sv
module fifo_mbox_hostif_mailbox #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set,
  input  logic         clr,
  input  logic [W-1:0] din,
  output logic         pend,
  output logic [W-1:0] dout
);
  // a set in the same cycle as a clear wins; contents survive a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      dout <= '0;
    end else if (set) begin
      pend <= 1'b1;
      dout <= din;
    end else if (clr) begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/fifo_mbox_hostif_status.sv
module fifo_mbox_hostif_status
  import fifo_mbox_hostif_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic [LW-1:0]     out_level,
  input  logic [LW-1:0]     in_level,
  input  logic              omb_pend,
  input  logic              imb_full,
  input  logic [NUM_EN-1:0] en,
  input  logic              irq_en,
  output logic [7:0]        status,
  output logic              out_full,
  output logic              in_empty,
  output logic              irq
);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  always_comb begin
    out_full  = (out_level == FULL_LVL);
    in_empty  = (in_level == '0);
    status            = '0;
    status[ST_OMB]    = omb_pend;
    status[ST_OFULL]  = out_full;
    status[ST_IEMPTY] = in_empty;
    status[ST_OHALF]  = at_half(32'(out_level), DEPTH);
    status[ST_IHALF]  = at_half(32'(in_level), DEPTH);
    status[ST_IMB]    = imb_full;
    status[ST_IFULL]  = (in_level == FULL_LVL);
    status[ST_OEMPTY] = (out_level == '0);
    irq = irq_en && (|irq_hits(status, en));
  end
endmodule

// File: rtl/fifo_mbox_hostif.sv
module fifo_mbox_hostif
  import fifo_mbox_hostif_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int MBW   = 6,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_mode,
  input  logic [2:0]    host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  output logic          out_push,
  output logic [15:0]   out_push_data,
  input  logic [LW-1:0] out_level,
  output logic          in_pop,
  input  logic [15:0]   in_pop_data,
  input  logic [LW-1:0] in_level,
  input  logic          brd_mb_take,
  input  logic          brd_mb_put,
  input  logic [MBW-1:0] brd_mb_wdata,
  output logic [MBW-1:0] out_mb_data,
  output logic          board_rst,
  input  logic          irq_en,
  output logic          irq
);
  localparam int PAD = 8 - MBW;

  logic wr_data, wr_high, wr_ctrl, wr_mail, wr_kick;
  logic rd_data, rd_high, rd_ctrl, rd_mail;

  fifo_mbox_hostif_decode u_dec (
    .addr(host_addr), .wr(host_wr), .rd(host_rd),
    .wr_data(wr_data), .wr_high(wr_high), .wr_ctrl(wr_ctrl),
    .wr_mail(wr_mail), .wr_kick(wr_kick),
    .rd_data(rd_data), .rd_high(rd_high), .rd_ctrl(rd_ctrl),
    .rd_mail(rd_mail)
  );

  // control: readback select plus the five enables, reserved bits not kept
  logic              rsel;
  logic [NUM_EN-1:0] en_q;
  logic [7:0]        wr_hi_q;
  logic [7:0]        rd_hi_q;
  logic              kick_q;

  // named events for the checker
  logic              out_full, in_empty;
  logic              imb_drain;
  logic              omb_pend, imb_full;
  logic [MBW-1:0]    imb_data;
  logic [7:0]        status;

  assign out_push      = wr_data && !out_full;
  assign out_push_data = word_mode ? {wr_hi_q, host_wdata} : {8'h00, host_wdata};
  assign in_pop        = rd_data && !in_empty;
  assign imb_drain     = rd_mail && !rsel;
  assign board_rst     = kick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsel    <= 1'b0;
      en_q    <= '0;
      wr_hi_q <= '0;
      rd_hi_q <= '0;
      kick_q  <= 1'b0;
    end else begin
      kick_q <= wr_kick;
      if (wr_ctrl) begin
        rsel <= host_wdata[CT_RSEL];
        en_q <= ctrl_enables(host_wdata);
      end
      if (wr_high) wr_hi_q <= host_wdata;
      if (in_pop && word_mode) rd_hi_q <= in_pop_data[15:8];
    end
  end

  fifo_mbox_hostif_mailbox #(.W(MBW)) u_omb (
    .clk(clk), .rst_n(rst_n),
    .set(wr_mail), .clr(brd_mb_take), .din(host_wdata[7:PAD]),
    .pend(omb_pend), .dout(out_mb_data)
  );

  fifo_mbox_hostif_mailbox #(.W(MBW)) u_imb (
    .clk(clk), .rst_n(rst_n),
    .set(brd_mb_put), .clr(imb_drain), .din(brd_mb_wdata),
    .pend(imb_full), .dout(imb_data)
  );

  fifo_mbox_hostif_status #(.DEPTH(DEPTH)) u_st (
    .out_level(out_level), .in_level(in_level),
    .omb_pend(omb_pend), .imb_full(imb_full),
    .en(en_q), .irq_en(irq_en),
    .status(status), .out_full(out_full), .in_empty(in_empty), .irq(irq)
  );

  always_comb begin
    host_rdata = 8'h00;
    if (rd_data)      host_rdata = in_pop_data[7:0];
    else if (rd_high) host_rdata = word_mode ? rd_hi_q : 8'h00;
    else if (rd_ctrl) host_rdata = status;
    else if (rd_mail) host_rdata = {(rsel ? out_mb_data : imb_data), {PAD{1'b0}}};
  end
endmodule

// File: rtl/fifo_mbox_hostif_chk.sv
module fifo_mbox_hostif_chk #(
  parameter int DEPTH = 16,
  parameter int MBW   = 6,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2:0]     host_addr,
  input logic           host_wr,
  input logic           host_rd,
  input logic [7:0]     host_rdata,
  input logic           out_push,
  input logic           in_pop,
  input logic [LW-1:0]  out_level,
  input logic [LW-1:0]  in_level,
  input logic           brd_mb_take,
  input logic           brd_mb_put,
  input logic [MBW-1:0] out_mb_data,
  input logic           board_rst,
  input logic           irq_en,
  input logic           irq,
  input logic           omb_pend,
  input logic           imb_full,
  input logic           rsel
);
  assert_no_push_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_push |-> (out_level != LW'(DEPTH)));

  assert_no_pop_when_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_pop |-> (in_level != '0));

  assert_omb_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 3'd3) |=> omb_pend);

  assert_omb_take_keeps_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (brd_mb_take && !(host_wr && host_addr == 3'd3)) |=> (!omb_pend && $stable(out_mb_data)));

  assert_imb_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    brd_mb_put |=> imb_full);

  assert_imb_drains_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 3'd3 && !rsel && !brd_mb_put) |=> !imb_full);

  assert_rsel_keeps_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 3'd3 && rsel && imb_full) |=> imb_full);

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  assert_kick_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 3'd7) |=> board_rst);

  assert_kick_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    board_rst |-> $past(host_wr && host_addr == 3'd7));

  assert_nop_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 3'd7) |-> (host_rdata == 8'h00 && !in_pop));
endmodule

bind fifo_mbox_hostif fifo_mbox_hostif_chk #(.DEPTH(DEPTH), .MBW(MBW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
  .host_rd(host_rd), .host_rdata(host_rdata), .out_push(out_push),
  .in_pop(in_pop), .out_level(out_level), .in_level(in_level),
  .brd_mb_take(brd_mb_take), .brd_mb_put(brd_mb_put),
  .out_mb_data(out_mb_data), .board_rst(board_rst), .irq_en(irq_en),
  .irq(irq), .omb_pend(omb_pend), .imb_full(imb_full), .rsel(rsel)
);

// File: tb/fifo_mbox_hostif_tb.sv
`timescale 1ns/1ps
module fifo_mbox_hostif_tb;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_mode = 1'b0;
  logic [2:0] host_addr = '0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic out_push;
  logic [15:0] out_push_data;
  logic [LW-1:0] out_level = '0, in_level = '0;
  logic in_pop;
  logic [15:0] in_pop_data = '0;
  logic brd_mb_take = 1'b0, brd_mb_put = 1'b0;
  logic [5:0] brd_mb_wdata = '0;
  logic [5:0] out_mb_data;
  logic board_rst;
  logic irq_en = 1'b0;
  logic irq;

  always #2.5 clk = ~clk;

  fifo_mbox_hostif #(.DEPTH(DEPTH)) u_dut (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  // bench model of the flags
  bit m_omb = 0, m_imb = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(input int ol, input int il);
    logic [7:0] s;
    s = 8'h00;
    if (m_omb)          s |= 8'h80;
    if (ol == DEPTH)    s |= 8'h40;
    if (il == 0)        s |= 8'h20;
    if (ol * 2 >= DEPTH) s |= 8'h10;
    if (il * 2 >= DEPTH) s |= 8'h08;
    if (m_imb)          s |= 8'h04;
    if (il == DEPTH)    s |= 8'h02;
    if (ol == 0)        s |= 8'h01;
    return s;
  endfunction

  // scoreboard monitor for reads
  initial forever begin
    @(negedge clk); #1;
    if (host_rd && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, host_rdata, e);
    end
  end

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d,
                        input bit ep, input logic [15:0] ed, input string tag);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    #1;
    chk({tag, " push"}, out_push, ep);
    if (ep) chk({tag, " push data"}, out_push_data, ed);
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, input logic [7:0] e,
                        input bit ep, input string tag);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    #1;
    chk({tag, " pop"}, in_pop, ep);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic levels(input int ol, input int il);
    @(negedge clk);
    out_level = LW'(ol); in_level = LW'(il);
  endtask

  task automatic put(input logic [5:0] d);
    @(negedge clk);
    brd_mb_put = 1'b1; brd_mb_wdata = d;
    @(negedge clk);
    brd_mb_put = 1'b0;
    m_imb = 1;
  endtask

  task automatic take();
    @(negedge clk);
    brd_mb_take = 1'b1;
    @(negedge clk);
    brd_mb_take = 1'b0;
    m_omb = 0;
  endtask

  task automatic irq_chk(input bit e, input string tag);
    @(negedge clk); #1;
    chk(tag, irq, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    #1;
    chk("R10 irq", irq, 0);
    chk("R10 board_rst", board_rst, 0);
    bus_rd(3'd2, exp_status(0, 0), 0, "R10 status");
    bus_rd(3'd3, 8'h00, 0, "R10 mailbox");

    // R1 status patterns
    levels(8, 16); bus_rd(3'd2, exp_status(8, 16), 0, "R1 half/full");
    levels(16, 3); bus_rd(3'd2, exp_status(16, 3), 0, "R1 out full");
    levels(7, 7);  bus_rd(3'd2, exp_status(7, 7), 0, "R1 below half");

    // R2 writes
    levels(3, 0);
    word_mode = 1'b0;
    bus_wr(3'd0, 8'hA5, 1, 16'h00A5, "R2 byte");
    bus_wr(3'd1, 8'h3C, 0, 16'h0000, "R2 high stage");
    word_mode = 1'b1;
    bus_wr(3'd0, 8'h5A, 1, 16'h3C5A, "R2 word");
    word_mode = 1'b0;
    bus_wr(3'd0, 8'h5A, 1, 16'h005A, "R2 byte again");
    levels(16, 0);
    bus_wr(3'd0, 8'h11, 0, 16'h0000, "R2 full blocks");

    // R3 reads
    levels(5, 4);
    in_pop_data = 16'hBEEF;
    word_mode = 1'b1;
    bus_rd(3'd0, 8'hEF, 1, "R3 word low");
    in_pop_data = 16'h1234;
    bus_rd(3'd1, 8'hBE, 0, "R3 word high");
    word_mode = 1'b0;
    bus_rd(3'd1, 8'h00, 0, "R3 byte high");
    levels(5, 0);
    bus_rd(3'd0, 8'h34, 0, "R3 empty no pop");

    // R4 outbound mailbox
    levels(5, 5);
    bus_wr(3'd3, 8'hB7, 0, 16'h0000, "R4 mb write");
    m_omb = 1;
    #1; chk("R4 mb data", out_mb_data, 6'h2D);
    bus_rd(3'd2, exp_status(5, 5), 0, "R4 pending");
    take();
    bus_rd(3'd2, exp_status(5, 5), 0, "R4 taken");
    #1; chk("R4 data kept", out_mb_data, 6'h2D);

    // R5 inbound mailbox
    put(6'h15);
    bus_rd(3'd2, exp_status(5, 5), 0, "R5 full flag");
    bus_rd(3'd3, 8'h54, 0, "R5 read");
    m_imb = 0;
    bus_rd(3'd2, exp_status(5, 5), 0, "R5 drained");

    // R6 readback select
    bus_wr(3'd2, 8'h80, 0, 16'h0000, "R6 set select");
    put(6'h3F);
    bus_rd(3'd3, 8'hB4, 0, "R6 outbound readback");
    bus_rd(3'd2, exp_status(5, 5), 0, "R6 inbound flag kept");
    bus_wr(3'd2, 8'h00, 0, 16'h0000, "R6 clear select");
    bus_rd(3'd3, 8'hFC, 0, "R6 inbound read");
    m_imb = 0;
    bus_rd(3'd2, exp_status(5, 5), 0, "R6 drained");

    // R7 interrupts
    levels(0, 0);
    irq_en = 1'b1;
    bus_wr(3'd2, 8'h01, 0, 16'h0000, "R7 mask oempty");
    irq_chk(1, "R7 out empty");
    irq_en = 1'b0;
    irq_chk(0, "R7 global off");
    irq_en = 1'b1;
    bus_wr(3'd2, 8'h08, 0, 16'h0000, "R7 mask iempty");
    irq_chk(1, "R7 in empty");
    levels(16, 4);
    bus_wr(3'd2, 8'h04, 0, 16'h0000, "R7 mask ofull");
    irq_chk(1, "R7 out full");
    levels(5, 16);
    irq_chk(0, "R7 out full gone");
    bus_wr(3'd2, 8'h20, 0, 16'h0000, "R7 mask ifull");
    irq_chk(1, "R7 in full");
    levels(5, 5);
    bus_wr(3'd2, 8'h40, 0, 16'h0000, "R7 mask imb");
    irq_chk(0, "R7 no mailbox");
    put(6'h01);
    irq_chk(1, "R7 mailbox full");
    bus_rd(3'd3, 8'h04, 0, "R7 drain");
    m_imb = 0;
    irq_chk(0, "R7 mailbox drained");

    // R8 reserved control bits
    levels(8, 16);
    bus_wr(3'd2, 8'h12, 0, 16'h0000, "R8 reserved write");
    irq_chk(0, "R8 reserved ignored");
    bus_rd(3'd2, exp_status(8, 16), 0, "R8 status");
    bus_wr(3'd2, 8'h20, 0, 16'h0000, "R8 contrast");
    irq_chk(1, "R8 real enable");
    bus_wr(3'd2, 8'h00, 0, 16'h0000, "R8 clear");

    // R9 reset trigger and no-op read
    @(negedge clk);
    host_addr = 3'd7; host_wdata = 8'h00; host_wr = 1'b1;
    #1; chk("R9 rst during write", board_rst, 0);
    @(negedge clk);
    host_wr = 1'b0;
    #1; chk("R9 rst pulse", board_rst, 1);
    @(negedge clk);
    #1; chk("R9 rst ends", board_rst, 0);
    levels(5, 5);
    put(6'h2A);
    bus_rd(3'd7, 8'h00, 0, "R9 nop read");
    bus_rd(3'd2, exp_status(5, 5), 0, "R9 flags unchanged");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R10 actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule